// File: doc/BRIEF.md
# Bus Master Wait-State Sequencer

This block runs one memory read or write on a bus that it masters. Each access opens with a single address phase (T1). One or more data phases (T2) follow. An access is made longer only by adding data phases. There are two ways to add them, and both may be used on the same access. A 2-bit configuration field inserts a fixed number of programmed wait phases between T1 and the final data phase. A ready input can also hold the access open in extra data phases until the memory is able to answer.

A configuration bit chooses how ready is qualified.
- In synchronous mode, ready is sampled directly at the clock edge that ends each data phase. It is ignored during programmed waits.
- In asynchronous mode, ready first passes through a two-flop synchronizer. A synchronized ready that is seen at the end of the last programmed wait is accepted, and the next data phase then closes the access.

The surrounding logic pulses `start` with the address, direction, write data and configuration. It then watches `phase_o` and waits for the one-clock `done_o` pulse. For a read, the captured data is presented on `rdata_o` during that pulse.

Top module: `bus_wait_seq`

## Requirements
- R1: When idle (`phase_o` = 0), a `start` sampled high moves the sequencer to T1 (`phase_o` = 1) on the next clock. The phase encoding is 0 idle, 1 T1, 2 programmed wait, 3 data phase T2. T1 lasts exactly one clock.
- R2: The value N of `cfg_wait` (0 to 3) inserts exactly N programmed wait clocks (`phase_o` = 2) between T1 and the first T2.
- R3: In synchronous mode (`cfg_async` = 0), `rdy_in` is sampled at the end of each T2. A low level adds another T2. `rdy_in` is ignored during programmed waits.
- R4: In asynchronous mode (`cfg_async` = 1), `rdy_in` is used only after two synchronizer flops. If the synchronized ready is high at the end of the last programmed wait, the following T2 is the final one. Otherwise it is checked at the end of each T2. Earlier programmed waits ignore it.
- R5: `cfg_wait`, `cfg_async`, `addr_in`, `wr_in` and `wdata_in` are captured when `start` is accepted. Changing them during an access has no effect on it.
- R6: `done_o` is high for exactly one clock, the clock after the final T2, with `phase_o` back at 0.
- R7: For a read, `rdata_o` holds `rdata_in` as sampled at the end of the final T2 from the `done_o` pulse onward. A write leaves `rdata_o` unchanged.
- R8: `bus_addr_o`, `bus_wdata_o` and `bus_we_o` carry the captured values and stay stable from T1 through the final T2.
- R9: A `start` pulse during an access is ignored: the sequencer returns to idle after that access and stays there.
- R10: Synchronous active-high `rst` forces idle, `done_o` = 0 and `rdata_o` = 0, including in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an access (sampled in idle) |
| wr_in | input | 1 | 1 = write, 0 = read |
| addr_in | input | ADDR_W | Access address |
| wdata_in | input | DATA_W | Write data |
| cfg_wait | input | WAIT_W | Programmed wait count |
| cfg_async | input | 1 | 1 = asynchronous ready qualification |
| rdy_in | input | 1 | Ready from memory |
| rdata_in | input | DATA_W | Read data from memory |
| phase_o | output | 2 | Current bus phase (0 idle, 1 T1, 2 wait, 3 T2) |
| bus_addr_o | output | ADDR_W | Captured address |
| bus_wdata_o | output | DATA_W | Captured write data |
| bus_we_o | output | 1 | Captured write direction |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Read data latched at the final T2 |

## Verification
The bench uses the default parameters: 16-bit address and data, a 2-bit wait field and two synchronizer stages. With these, every programmed wait count from 0 to 3 can be reached in both ready modes within a few clocks. The fixed two-clock synchronizer latency also makes it simple to place a ready pulse exactly in the last programmed wait, or in an earlier one. That covers the asynchronous early acceptance, the ready pulses that synchronous mode must ignore, and combined programmed-plus-ready extensions.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_WAIT = 2'd2,
    PH_T2   = 2'd3
  } phase_e;
endpackage

// File: rtl/bws_rdy_qual.sv
module bws_rdy_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_in,
  input  logic async_sel,
  output logic rdy_q
);
  logic [SYNC_STAGES-1:0] chain;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= rdy_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], rdy_in};
      end
    end
  endgenerate

  assign rdy_q = async_sel ? chain[SYNC_STAGES-1] : rdy_in;
endmodule

// File: rtl/bws_wait_cnt.sv
module bws_wait_cnt #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt == WAIT_W'(1));
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WAIT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_async,
  input  logic              rdy_in,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [1:0]        phase_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  phase_e            state;
  logic [WAIT_W-1:0] cfg_wait_q;
  logic              cfg_async_q;
  logic              accept_q;
  logic              rdy_q;
  logic              wait_last;

  bws_rdy_qual #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
    .clk       (clk),
    .rst       (rst),
    .rdy_in    (rdy_in),
    .async_sel (cfg_async_q),
    .rdy_q     (rdy_q)
  );

  bws_wait_cnt #(.WAIT_W(WAIT_W)) u_wcnt (
    .clk      (clk),
    .rst      (rst),
    .load     (state == PH_T1),
    .load_val (cfg_wait_q),
    .dec      (state == PH_WAIT),
    .last_o   (wait_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      cfg_wait_q  <= '0;
      cfg_async_q <= 1'b0;
      accept_q    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_we_o    <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (start) begin
            state       <= PH_T1;
            cfg_wait_q  <= cfg_wait;
            cfg_async_q <= cfg_async;
            bus_addr_o  <= addr_in;
            bus_wdata_o <= wdata_in;
            bus_we_o    <= wr_in;
            accept_q    <= 1'b0;
          end
        end
        PH_T1: begin
          state <= (cfg_wait_q != '0) ? PH_WAIT : PH_T2;
        end
        PH_WAIT: begin
          if (wait_last) begin
            state <= PH_T2;
            if (cfg_async_q && rdy_q) accept_q <= 1'b1;
          end
        end
        PH_T2: begin
          if (accept_q || rdy_q) begin
            state  <= PH_IDLE;
            done_o <= 1'b1;
            if (!bus_we_o) rdata_o <= rdata_in;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = state;
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rdy_in,
  input logic [1:0]        phase_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [WAIT_W-1:0] cfg_wait_q,
  input logic              cfg_async_q
);
  logic [WAIT_W:0] tw_run;

  always_ff @(posedge clk) begin
    if (rst)                tw_run <= '0;
    else if (phase_o == 2'd2) tw_run <= tw_run + 1'b1;
    else                    tw_run <= '0;
  end

  // R1
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0 && start) |=> phase_o == 2'd1);

  // R1
  t1_single_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd1) |=> (phase_o == 2'd2 || phase_o == 2'd3));

  // R2
  wait_count_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3 && $past(phase_o) == 2'd2) |-> tw_run == {1'b0, cfg_wait_q});

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_async_q && phase_o == 2'd3 && !rdy_in) |=> phase_o == 2'd3);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phase_o == 2'd0 && $past(phase_o) == 2'd3));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd0 && $past(phase_o) != 2'd0) |-> $stable(bus_addr_o));
endmodule

bind bus_wait_seq bws_chk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .rdy_in      (rdy_in),
  .phase_o     (phase_o),
  .done_o      (done_o),
  .bus_addr_o  (bus_addr_o),
  .cfg_wait_q  (cfg_wait_q),
  .cfg_async_q (cfg_async_q)
);

// File: tb/bus_wait_seq_tb.sv
`timescale 1ns/1ps
module bus_wait_seq_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int WAIT_W = 2;

  typedef struct packed {
    logic       wr;
    logic       asy;
    logic [1:0] w;
    int         ron;
    int         plo;
    int         phi;
    int         fin;
  } vec_t;

  // wr, async, wait, ready-on cycle, pulse lo, pulse hi, final T2 cycle
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, -5, 20, 0, 1},
    '{1'b0, 1'b0, 2'd1, -5, 20, 0, 2},
    '{1'b1, 1'b0, 2'd2, -5, 20, 0, 3},
    '{1'b0, 1'b0, 2'd3, -5, 20, 0, 4},
    '{1'b0, 1'b0, 2'd0,  4, 20, 0, 4},
    '{1'b1, 1'b0, 2'd2,  6, 20, 0, 6},
    '{1'b0, 1'b1, 2'd0, -5, 20, 0, 1},
    '{1'b0, 1'b1, 2'd3, -5, 20, 0, 4},
    '{1'b1, 1'b1, 2'd1,  3, 20, 0, 5},
    '{1'b0, 1'b1, 2'd2,  0, 20, 0, 3},
    '{1'b0, 1'b0, 2'd3,  9,  1, 3, 9},
    '{1'b0, 1'b1, 2'd3,  9,  1, 1, 4},
    '{1'b0, 1'b0, 2'd2,  7,  2, 2, 7},
    '{1'b0, 1'b1, 2'd3,  8,  0, 0, 10}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              wr_in = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [DATA_W-1:0] wdata_in = '0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic              cfg_async = 1'b0;
  logic              rdy_in = 1'b0;
  logic [DATA_W-1:0] rdata_in = '0;
  logic [1:0]        phase_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic              bus_we_o;
  logic              done_o;
  logic [DATA_W-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] last_rd = '0;

  always #2.5 clk = ~clk;

  bus_wait_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .wr_in(wr_in), .addr_in(addr_in),
    .wdata_in(wdata_in), .cfg_wait(cfg_wait), .cfg_async(cfg_async),
    .rdy_in(rdy_in), .rdata_in(rdata_in), .phase_o(phase_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_we_o(bus_we_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy_at(input int c, input int ron, input int plo, input int phi);
    return (c >= ron) || (c >= plo && c <= phi);
  endfunction

  // One access; cycle 0 is T1. Outputs are sampled at each falling edge.
  task automatic run_access(input logic wr, input logic asy, input logic [1:0] w,
                            input int ron, input int plo, input int phi,
                            input int fin, input int idx, input int extra_start);
    for (int c = -3; c <= fin + 2; c++) begin
      @(negedge clk);
      if (c == -1) begin
        start    = 1'b1;
        wr_in    = wr;
        cfg_async = asy;
        cfg_wait = w;
        addr_in  = ADDR_W'(16'h1000 + idx);
        wdata_in = DATA_W'(16'hA000 + idx);
        rdata_in = DATA_W'(16'h5000 + idx);
      end else begin
        start = (c == extra_start);
      end
      if (c >= 0) begin
        // R5: disturb every captured input during the access
        cfg_wait  = ~w;
        cfg_async = ~asy;
        addr_in   = ~addr_in;
        wr_in     = ~wr;
        wdata_in  = ~wdata_in;
        if (c == 0)
          chk(phase_o == 2'd1, "R1", "T1 after start", phase_o, 1);
        else if (c <= int'(w))
          chk(phase_o == 2'd2, "R2", "programmed wait", phase_o, 2);
        else if (c <= fin)
          chk(phase_o == 2'd3, asy ? "R4" : "R3", "data phase", phase_o, 3);
        else if (c == fin + 1)
          chk(phase_o == 2'd0, "R6", "idle after final T2", phase_o, 0);
        else
          chk(phase_o == 2'd0, "R9", "stays idle", phase_o, 0);
        chk(done_o == (c == fin + 1), "R6", "done pulse", done_o, c == fin + 1);
        if (c == 0 || c == fin) begin
          chk(bus_addr_o == ADDR_W'(16'h1000 + idx), "R8", "address", bus_addr_o, 16'h1000 + idx);
          chk(bus_we_o == wr, "R8", "direction", bus_we_o, wr);
          chk(bus_wdata_o == DATA_W'(16'hA000 + idx), "R8", "write data", bus_wdata_o, 16'hA000 + idx);
        end
        if (c == fin + 1) begin
          if (!wr) last_rd = DATA_W'(16'h5000 + idx);
          chk(rdata_o == last_rd, "R7", "read data", rdata_o, last_rd);
        end
      end
      rdy_in = rdy_at(c, ron, plo, phi);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(phase_o == 2'd0, "R10", "reset phase", phase_o, 0);
    chk(done_o == 1'b0, "R10", "reset done", done_o, 0);
    chk(rdata_o == '0, "R10", "reset rdata", rdata_o, 0);

    for (int i = 0; i < NV; i++)
      run_access(VECS[i].wr, VECS[i].asy, VECS[i].w, VECS[i].ron,
                 VECS[i].plo, VECS[i].phi, VECS[i].fin, i, -100);

    // R9: start pulse during programmed waits is ignored
    run_access(1'b0, 1'b0, 2'd3, -5, 20, 0, 4, 20, 2);

    // R10: reset in the middle of an access
    @(negedge clk);
    rdy_in = 1'b0; start = 1'b1; cfg_wait = 2'd3; cfg_async = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(phase_o == 2'd0, "R10", "reset mid-access phase", phase_o, 0);
    chk(rdata_o == '0, "R10", "reset mid-access rdata", rdata_o, 0);
    last_rd = '0;
    @(negedge clk);
    chk(phase_o == 2'd0, "R10", "idle after reset", phase_o, 0);

    run_access(1'b0, 1'b1, 2'd1, -5, 20, 0, 2, 30, -100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule